// File: doc/BRIEF.md
# Dual-Pipe Thread Issue Arbiter

This block picks which hardware threads of one execution unit issue instructions in a given cycle. The unit holds seven threads and feeds two identical execution pipes. Each thread shows a ready flag, a flag that names the pipe it prefers, and an instruction tag. Each cycle the arbiter gives each pipe at most one ready thread, so at most two instructions leave per cycle. The same thread is never sent to both pipes at once.

Each pipe keeps its own round-robin pointer. Pipe X chooses first. Pipe Y then chooses from the ready threads that pipe X did not take. When only one thread is ready, its preference flag decides which pipe it goes to, and the other pipe idles. A pipe can refuse work through its stall input. While stalled it gets no grant and its pointer stays where it is. The choice made from the inputs of one cycle appears on registered outputs at the next clock edge.

Top module: `dual_issue_arb`

## Requirements
- R1: Threads are numbered 0 to 6. The inputs sampled at one rising edge decide the issue outputs (`iss_vld`, `iss_tid`, `iss_tag`, `thr_gnt`), which hold their new values from that edge until the next one. Bit 0 of every two-bit pipe vector is pipe X and bit 1 is pipe Y.
- R2: A pipe is granted only a thread whose `thr_ready` bit was 1 in the deciding cycle. `iss_tag` for that pipe equals that thread's `thr_tag` from the same cycle.
- R3: Each pipe gets at most one thread per cycle. `thr_gnt` has bit i set exactly when thread i was granted to some pipe, so it has at most two bits set.
- R4: When both pipes are valid, their thread indices differ.
- R5: Pipe X, when not stalled, takes the first eligible thread found by scanning upward from its pointer, wrapping from 6 to 0.
- R6: Pipe Y, when not stalled, takes the first eligible thread found by scanning upward from its own pointer. The thread granted to pipe X in the same cycle is excluded from this scan.
- R7: After a pipe issues thread t, its pointer becomes (t+1) mod 7. When the pipe does not issue, the pointer keeps its value.
- R8: When exactly one thread is ready, it can go only to the pipe its `thr_pref` bit names (0 = pipe X, 1 = pipe Y), and the other pipe stays idle. If that pipe is stalled, nothing issues. With two or more ready threads, the preference flags have no effect.
- R9: A pipe with `pipe_stall` high in the deciding cycle issues nothing and its pointer holds. If pipe X is stalled, pipe Y scans all eligible threads with nothing excluded.
- R10: While `rst` is high at a clock edge, both pointers return to 0 and all issue outputs clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| thr_ready | input | 7 | Per-thread ready flag |
| thr_pref | input | 7 | Per-thread preferred pipe (0 = X, 1 = Y) |
| thr_tag | input | 7 x 8 | Per-thread instruction tag |
| pipe_stall | input | 2 | Per-pipe stall, bit 0 = X, bit 1 = Y |
| iss_vld | output | 2 | Pipe issue valid, bit 0 = X, bit 1 = Y |
| iss_tid | output | 2 x 3 | Thread index issued to each pipe |
| iss_tag | output | 2 x 8 | Tag issued to each pipe |
| thr_gnt | output | 7 | Threads granted to any pipe |

## Verification
Assertions inside the RTL check these properties every cycle:
- no thread is issued to both pipes;
- the grant vector's population matches the valid pipes;
- every granted thread was ready;
- a stalled pipe neither issues nor moves its pointer;
- each pointer lands one past the thread it issued;
- the outputs clear after reset.

The exact round-robin order cannot be shown by these cycle-local properties. The same holds for the pipe Y exclusion when pipe X is stalled, the single-ready steering by preference, and the tags carried along. The bench shows these by comparing every cycle against a behavioural model, across rotations with all threads ready, wrap-around pairs, lone ready threads with each preference, stall patterns and long random traffic.

// File: rtl/issue_arb_pkg.sv
package issue_arb_pkg;

    // Pipe identifiers; the thread preference bit uses the same coding.
    typedef enum logic {
        PIPE_X = 1'b0,
        PIPE_Y = 1'b1
    } pipe_e;

    localparam int PIPES = 2;

    // Index one past idx, wrapping at n.
    function automatic int wrap_next(int idx, int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

    // base + k modulo n, for base and k below n.
    function automatic int wrap_add(int base, int k, int n);
        int s;
        s = base + k;
        return (s >= n) ? s - n : s;
    endfunction

endpackage

// File: rtl/thread_scan.sv
module thread_scan
    import issue_arb_pkg::*;
#(
    parameter int NUM_THR = 7,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_THR-1:0] req,
    input  logic [IDX_W-1:0]   start,
    output logic               found,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_THR-1:0] onehot
);

    // Candidate thread visited at scan step k.
    logic [IDX_W-1:0] cand [NUM_THR];

    for (genvar k = 0; k < NUM_THR; k++) begin : g_cand
        assign cand[k] = IDX_W'(wrap_add(int'(start), k, NUM_THR));
    end

    always_comb begin
        found  = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int k = 0; k < NUM_THR; k++) begin
            if (!found && req[cand[k]]) begin
                found          = 1'b1;
                idx            = cand[k];
                onehot[cand[k]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pipe_lane.sv
module pipe_lane
    import issue_arb_pkg::*;
#(
    parameter int NUM_THR = 7,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall,
    input  logic [NUM_THR-1:0] elig,
    input  logic [NUM_THR-1:0] excl,
    output logic               gnt_vld,
    output logic [IDX_W-1:0]   gnt_idx,
    output logic [NUM_THR-1:0] gnt_oh
);

    logic [IDX_W-1:0]   ptr_q;
    logic [NUM_THR-1:0] req;

    // A stalled lane requests nothing; threads taken upstream are removed.
    assign req = elig & ~excl & {NUM_THR{~stall}};

    thread_scan #(
        .NUM_THR (NUM_THR),
        .IDX_W   (IDX_W)
    ) u_scan (
        .req    (req),
        .start  (ptr_q),
        .found  (gnt_vld),
        .idx    (gnt_idx),
        .onehot (gnt_oh)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (gnt_vld) begin
            ptr_q <= IDX_W'(wrap_next(int'(gnt_idx), NUM_THR));
        end
    end

    // R9: a stalled lane keeps its pointer.
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(ptr_q));

    // R7: the pointer lands one past the thread just issued.
    p_ptr_adv_r7: assert property (@(posedge clk) disable iff (rst)
        gnt_vld |=> ptr_q == IDX_W'(wrap_next(int'($past(gnt_idx)), NUM_THR)));

    // R7: the pointer always names a real thread.
    p_ptr_range_r7: assert property (@(posedge clk) disable iff (rst)
        int'(ptr_q) < NUM_THR);

endmodule

// File: rtl/dual_issue_arb.sv
module dual_issue_arb
    import issue_arb_pkg::*;
#(
    parameter  int NUM_THR = 7,
    parameter  int TAG_W   = 8,
    localparam int IDX_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_THR-1:0]            thr_ready,
    input  logic [NUM_THR-1:0]            thr_pref,
    input  logic [NUM_THR-1:0][TAG_W-1:0] thr_tag,
    input  logic [1:0]                    pipe_stall,
    output logic [1:0]                    iss_vld,
    output logic [1:0][IDX_W-1:0]         iss_tid,
    output logic [1:0][TAG_W-1:0]         iss_tag,
    output logic [NUM_THR-1:0]            thr_gnt
);

    logic                            solo;
    logic [PIPES-1:0][NUM_THR-1:0]   elig;
    logic [PIPES:0][NUM_THR-1:0]     taken;
    logic [PIPES-1:0]                pick_vld;
    logic [PIPES-1:0][IDX_W-1:0]     pick_idx;
    logic [PIPES-1:0][NUM_THR-1:0]   pick_oh;

    // Preference steering applies only to a lone ready thread.
    assign solo     = ($countones(thr_ready) == 1);
    assign taken[0] = '0;

    for (genvar p = 0; p < PIPES; p++) begin : g_lane
        localparam pipe_e LANE = pipe_e'(p);

        logic [NUM_THR-1:0] pref_match;
        assign pref_match = (LANE == PIPE_Y) ? thr_pref : ~thr_pref;
        assign elig[p]    = solo ? (thr_ready & pref_match) : thr_ready;

        // Lanes are chained: each later lane skips what earlier lanes took.
        pipe_lane #(
            .NUM_THR (NUM_THR),
            .IDX_W   (IDX_W)
        ) u_lane (
            .clk     (clk),
            .rst     (rst),
            .stall   (pipe_stall[p]),
            .elig    (elig[p]),
            .excl    (taken[p]),
            .gnt_vld (pick_vld[p]),
            .gnt_idx (pick_idx[p]),
            .gnt_oh  (pick_oh[p])
        );

        assign taken[p+1] = taken[p] | pick_oh[p];

        always_ff @(posedge clk) begin
            if (rst) begin
                iss_vld[p] <= 1'b0;
                iss_tid[p] <= '0;
                iss_tag[p] <= '0;
            end else begin
                iss_vld[p] <= pick_vld[p];
                iss_tid[p] <= pick_idx[p];
                iss_tag[p] <= pick_vld[p] ? thr_tag[pick_idx[p]] : '0;
            end
        end

        // R9: a pipe stalled in the deciding cycle shows no issue.
        p_stall_idle_r9: assert property (@(posedge clk) disable iff (rst)
            $past(pipe_stall[p]) |-> !iss_vld[p]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_gnt <= '0;
        end else begin
            thr_gnt <= taken[PIPES];
        end
    end

    // R10: reset leaves every issue output idle.
    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> (iss_vld == 2'b00) && (thr_gnt == '0));

    // R4: the two pipes never carry the same thread.
    p_no_dual_r4: assert property (@(posedge clk) disable iff (rst)
        (&iss_vld) |-> (iss_tid[0] != iss_tid[1]));

    // R3: one grant bit per valid pipe.
    p_gnt_count_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(thr_gnt) == $countones(iss_vld));

    // R2: granted threads were ready in the deciding cycle.
    p_ready_only_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(thr_ready) & thr_gnt) == thr_gnt);

    // R8: a lone ready thread occupies at most one pipe.
    p_solo_single_r8: assert property (@(posedge clk) disable iff (rst)
        ($countones($past(thr_ready)) == 1) |-> ($countones(iss_vld) <= 1));

endmodule

// File: tb/test_dual_issue_arb.sv
module test_dual_issue_arb;

    localparam int N  = 7;
    localparam int TW = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic [N-1:0]      thr_ready;
    logic [N-1:0]      thr_pref;
    logic [N-1:0][TW-1:0] thr_tag;
    logic [1:0]        pipe_stall;
    logic [1:0]        iss_vld;
    logic [1:0][2:0]   iss_tid;
    logic [1:0][TW-1:0] iss_tag;
    logic [N-1:0]      thr_gnt;

    always #5 clk = ~clk;

    dual_issue_arb #(.NUM_THR(N), .TAG_W(TW)) i_dual_issue_arb (
        .clk        (clk),
        .rst        (rst),
        .thr_ready  (thr_ready),
        .thr_pref   (thr_pref),
        .thr_tag    (thr_tag),
        .pipe_stall (pipe_stall),
        .iss_vld    (iss_vld),
        .iss_tid    (iss_tid),
        .iss_tag    (iss_tag),
        .thr_gnt    (thr_gnt)
    );

    int     checks = 0;
    int     fails  = 0;
    bit     done   = 0;
    string  cur_req = "R10";

    // Reference model state
    int           mptr [2];
    bit           ev   [2];
    int           et   [2];
    logic [TW-1:0] eg  [2];
    logic [N-1:0] egnt;

    function automatic int first_from(logic [N-1:0] m, int start);
        for (int k = 0; k < N; k++) begin
            int c;
            c = (start + k) % N;
            if (m[c]) return c;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mptr[0] = 0; mptr[1] = 0;
            ev[0] = 0; ev[1] = 0;
            et[0] = 0; et[1] = 0;
            eg[0] = '0; eg[1] = '0;
            egnt = '0;
        end else begin
            int           nready, gx, gy;
            logic [N-1:0] ex, ey;
            nready = $countones(thr_ready);
            ex = (nready == 1) ? (thr_ready & ~thr_pref) : thr_ready;
            ey = (nready == 1) ? (thr_ready & thr_pref)  : thr_ready;
            gx = pipe_stall[0] ? -1 : first_from(ex, mptr[0]);
            if (gx >= 0) ey[gx] = 1'b0;
            gy = pipe_stall[1] ? -1 : first_from(ey, mptr[1]);
            egnt = '0;
            ev[0] = (gx >= 0); ev[1] = (gy >= 0);
            et[0] = (gx >= 0) ? gx : 0;
            et[1] = (gy >= 0) ? gy : 0;
            eg[0] = (gx >= 0) ? thr_tag[gx] : '0;
            eg[1] = (gy >= 0) ? thr_tag[gy] : '0;
            if (gx >= 0) begin egnt[gx] = 1'b1; mptr[0] = (gx + 1) % N; end
            if (gy >= 0) begin egnt[gy] = 1'b1; mptr[1] = (gy + 1) % N; end
        end
    end

    task automatic compare();
        for (int p = 0; p < 2; p++) begin
            checks++;
            if (iss_vld[p] !== ev[p]) begin
                fails++;
                $display("FAIL %s pipe%0d valid: got %0b exp %0b", cur_req, p, iss_vld[p], ev[p]);
            end else if (ev[p]) begin
                checks++;
                if (int'(iss_tid[p]) != et[p] || iss_tag[p] !== eg[p]) begin
                    fails++;
                    $display("FAIL %s pipe%0d tid/tag: got %0d/%0h exp %0d/%0h",
                             cur_req, p, iss_tid[p], iss_tag[p], et[p], eg[p]);
                end
            end
        end
        checks++;
        if (thr_gnt !== egnt) begin
            fails++;
            $display("FAIL %s R3 grant vector: got %b exp %b", cur_req, thr_gnt, egnt);
        end
        if (iss_vld === 2'b11) begin
            checks++;
            if (iss_tid[0] == iss_tid[1]) begin
                fails++;
                $display("FAIL R4 same thread on both pipes: got %0d/%0d exp distinct",
                         iss_tid[0], iss_tid[1]);
            end
        end
    endtask

    task automatic cyc(logic [N-1:0] rdy, logic [N-1:0] prf, logic [1:0] stl);
        thr_ready  = rdy;
        thr_pref   = prf;
        pipe_stall = stl;
        for (int k = 0; k < N; k++) thr_tag[k] = TW'($urandom);
        @(negedge clk);
        compare();
    endtask

    initial begin
        rst = 1'b1;
        thr_ready = '0; thr_pref = '0; pipe_stall = '0; thr_tag = '0;
        // R10: outputs idle under reset, even with traffic present
        cur_req = "R10";
        @(negedge clk);
        thr_ready = '1;
        repeat (3) begin @(negedge clk); compare(); end
        rst = 1'b0;

        // R1 R5 R6 R7: all ready rotation starting from pointers at 0
        cur_req = "R1 R5 R6 R7";
        repeat (12) cyc('1, 7'($urandom), 2'b00);

        // R5 R6: wrap-around pairs
        cur_req = "R5 R6";
        cyc(7'b1000001, '0, 2'b00);
        cyc(7'b1000001, '0, 2'b00);
        cyc(7'b0110000, '0, 2'b00);
        cyc(7'b1000010, '1, 2'b00);
        cyc('0, '0, 2'b00);

        // R8: a lone ready thread follows its preference
        cur_req = "R8";
        for (int t = 0; t < N; t++) begin
            cyc(7'(1 << t), '0, 2'b00);
            cyc(7'(1 << t), '1, 2'b00);
        end
        cyc(7'b0001000, 7'b0001000, 2'b10);
        cyc(7'b0001000, 7'b0000000, 2'b01);
        cyc(7'b0000100, 7'b0000100, 2'b01);

        // R9: stalls with several threads ready
        cur_req = "R9";
        repeat (6) cyc('1, '0, 2'b01);
        repeat (6) cyc('1, '0, 2'b10);
        repeat (3) cyc('1, '0, 2'b11);
        repeat (10) cyc(7'($urandom), 7'($urandom), 2'($urandom));

        // R2 R3 R4: long random traffic
        cur_req = "R2 R3 R4";
        repeat (1500) begin
            logic [1:0] s;
            s = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
            cyc(7'($urandom), 7'($urandom), s);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule